// File: doc/BRIEF.md
# Bidirectional Custom-Order State Counter

This block is a small synchronous Moore machine holding a 3-bit state. The state walks a fixed, non-binary ring that contains every value 0 through 7 exactly once. One direction input sets the way the walk goes on each enabled clock edge. Forward stepping follows 1, 3, 5, 7, 6, 4, 2, 0 and then wraps back to 1. Backward stepping walks the same ring in the opposite order.

The state sits in three D flip-flops with plain binary encoding. The three outputs are the state bits, taken straight from those registers. A synchronous reset puts the machine at value 1. An enable input freezes the state while it is low. The ring order is fixed and is held in a package function, so the successor and predecessor logic both come from one definition.

Top module: `ring_step_counter`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state output `cnt` becomes 1 (binary 001) after that edge.
- R2: With `en`=1 and `fwd`=1, each rising edge moves `cnt` to its forward successor: 1→3, 3→5, 5→7, 7→6, 6→4, 4→2, 2→0, 0→1.
- R3: With `en`=1 and `fwd`=0, each rising edge moves `cnt` to its backward successor: 1→0, 0→2, 2→4, 4→6, 6→7, 7→5, 5→3, 3→1.
- R4: With `en`=0 and `rst`=0, `cnt` holds its value across the edge whatever the value of `fwd`.
- R5: Eight consecutive enabled steps in one direction visit eight distinct values and return to the starting value.
- R6: `fwd` is sampled at each edge. A change of direction takes effect on the very next step, so one forward step followed by one backward step returns to the original value.
- R7: `cnt[2]`, `cnt[1]` and `cnt[0]` are the registered state bits in plain binary, MSB first. Every value 0..7 is a legal, reachable state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to value 1 |
| en | input | 1 | Step enable, active high |
| fwd | input | 1 | Direction: 1 forward, 0 backward |
| cnt | output | 3 | Registered state value, binary |

## Verification
The case that is hardest to reach is a direction reversal at every possible ring position, including the wrap pair 0 and 1. It is also hard to check that holding with `en` low ignores `fwd`. A random walk driven by $urandom, with `en` and `fwd` both random, covers every position and both reversal orders. Directed full laps in each direction, plus a forward-then-back pair at each of the eight starting points, complete the coverage.

// File: rtl/ring_step_pkg.sv
package ring_step_pkg;
  localparam int unsigned W = 3;
  localparam int unsigned N = 1 << W;
  typedef logic [W-1:0] state_t;

  // position of each value on the ring (value -> index)
  function automatic int unsigned pos_of(input state_t v);
    case (v)
      3'd1: pos_of = 0;
      3'd3: pos_of = 1;
      3'd5: pos_of = 2;
      3'd7: pos_of = 3;
      3'd6: pos_of = 4;
      3'd4: pos_of = 5;
      3'd2: pos_of = 6;
      default: pos_of = 7;
    endcase
  endfunction

  // value at each ring index (index -> value)
  function automatic state_t val_at(input int unsigned p);
    case (p % N)
      0: val_at = 3'd1;
      1: val_at = 3'd3;
      2: val_at = 3'd5;
      3: val_at = 3'd7;
      4: val_at = 3'd6;
      5: val_at = 3'd4;
      6: val_at = 3'd2;
      default: val_at = 3'd0;
    endcase
  endfunction

  localparam state_t RESET_VAL = 3'd1;
endpackage

// File: rtl/ring_next.sv
module ring_next
  import ring_step_pkg::*;
#(
  parameter bit FORWARD = 1'b1
) (
  input  state_t cur,
  output state_t nxt
);
  localparam int unsigned STEP = FORWARD ? 1 : N - 1;

  always_comb begin
    nxt = val_at(pos_of(cur) + STEP);
  end

  always_comb begin
    assert_ring_link_R2_R3: assert (pos_of(val_at(pos_of(cur) + STEP)) == (pos_of(cur) + STEP) % N)
      else $error("ring link broken");
  end
endmodule

// File: rtl/ring_step_counter.sv
module ring_step_counter
  import ring_step_pkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic         fwd,
  output logic [2:0]   cnt
);
  state_t st_q, nxt_fw, nxt_bw;

  ring_next #(.FORWARD(1'b1)) u_fw (.cur(st_q), .nxt(nxt_fw));
  ring_next #(.FORWARD(1'b0)) u_bw (.cur(st_q), .nxt(nxt_bw));

  always_ff @(posedge clk) begin
    if (rst)      st_q <= RESET_VAL;
    else if (en)  st_q <= fwd ? nxt_fw : nxt_bw;
  end

  assign cnt = st_q;

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
  end

  assert_reset_val_R1: assert property (@(posedge clk) rst |=> cnt == 3'd1);
  assert_hold_R4: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    !en |=> $stable(cnt));
  assert_moves_R7: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    en |=> !$stable(cnt));
  assert_fw_pair_R2: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (en && fwd && cnt == 3'd7) |=> cnt == 3'd6);
  assert_bw_pair_R3: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (en && !fwd && cnt == 3'd0) |=> cnt == 3'd2);
endmodule

// File: tb/ring_step_counter_test.sv
`timescale 1ns/1ps
module ring_step_counter_test;
  logic clk = 0, rst = 1, en = 0, fwd = 1;
  logic [2:0] cnt;
  int checks = 0, fails = 0;

  ring_step_counter uut (.clk(clk), .rst(rst), .en(en), .fwd(fwd), .cnt(cnt));
  always #4 clk = ~clk;

  localparam logic [2:0] RING [8] = '{3'd1,3'd3,3'd5,3'd7,3'd6,3'd4,3'd2,3'd0};
  function automatic logic [2:0] step(input logic [2:0] v, input logic f);
    for (int i = 0; i < 8; i++)
      if (RING[i] == v) return f ? RING[(i+1)%8] : RING[(i+7)%8];
    return 3'bx;
  endfunction

  task automatic chk(input string r, input logic [2:0] a, input logic [2:0] e);
    checks++;
    if (a !== e) begin fails++; $display("FAIL %s actual=%0d expected=%0d", r, a, e); end
  endtask

  task automatic tick(input logic r, input logic e, input logic f);
    rst = r; en = e; fwd = f;
    @(posedge clk); #2;
  endtask

  initial begin
    #200000;
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end

  initial begin
    logic [2:0] exp, start;
    logic [7:0] seen;
    void'($urandom(32'd1234));
    @(negedge clk);
    tick(1, 0, 1); chk("R1 reset", cnt, 3'd1);
    // full laps each direction (R2, R3, R5, R7)
    for (int d = 0; d < 2; d++) begin
      start = cnt; exp = cnt; seen = '0;
      for (int k = 0; k < 8; k++) begin
        tick(0, 1, d == 0);
        exp = step(exp, d == 0);
        seen[cnt] = 1'b1;
        chk(d == 0 ? "R2 fwd step" : "R3 bwd step", cnt, exp);
      end
      chk("R5 lap return", cnt, start);
      chk("R5 R7 all distinct", {5'd0, 3'($countones(seen) == 8)}, 3'd1);
    end
    // forward then backward at every position (R6)
    for (int k = 0; k < 8; k++) begin
      start = cnt;
      tick(0, 1, 1); tick(0, 1, 0);
      chk("R6 reverse", cnt, start);
      tick(0, 1, 1);
    end
    // hold with en low, both directions (R4)
    start = cnt;
    tick(0, 0, 1); chk("R4 hold fwd", cnt, start);
    tick(0, 0, 0); chk("R4 hold bwd", cnt, start);
    // reset mid-run with enable high (R1)
    tick(0, 1, 1); tick(1, 1, 0); chk("R1 reset over en", cnt, 3'd1);
    // random walk
    exp = cnt;
    for (int k = 0; k < 400; k++) begin
      logic e, f;
      e = $urandom_range(0, 3) != 0; f = $urandom_range(0, 1);
      tick(0, e, f);
      if (e) exp = step(exp, f);
      chk(e ? (f ? "R2 random" : "R3 random") : "R4 random", cnt, exp);
    end
    $display("%0d/%0d checks passed", checks-fails, checks);
    $finish;
  end
endmodule